// File: doc/BRIEF.md
# Receive Frame Page Writer

This block accepts one incoming Ethernet frame at a time as a byte stream. A start pulse carries the frame length, and a last flag marks the final byte. The block writes the frame into a single 2048-byte packet page through a byte-wide write port. The page layout is fixed:

- a 16-bit status word;
- a 16-bit stored byte count;
- the data bytes, zero-padded to the minimum frame size;
- an optional CRC-32;
- a two-byte trailer that holds the final odd byte, if there is one.

At frame start the block decides whether the frame can be taken. It checks the receive enable, the soft-reset control, the receive-queue-full indication and whether the laid-out frame fits in a page. If the frame can be taken, it asks an external page allocator for a page through a request/acknowledge handshake. While that request is pending the byte stream is held off. A refused frame is still consumed from the stream but nothing is written. Once the whole layout is in the page, the page number is pushed to the external receive queue and a receive event strobe is raised in the same cycle.

Top module: `rxw_top`

## Requirements
- R1: A frame that starts while `rx_en` is low or `soft_rst` is high is discarded: no page request, no page write, no queue push.
- R2: A page is requested only in response to a frame start, and `alloc_req` stays high until `alloc_ack`. If the acknowledge arrives with `alloc_ok` low, or `q_full` is high at frame start, the frame is discarded with no write and no push.
- R3: Data byte i of an accepted frame is written at page offset 4+i. `in_ready` stays low while the page request is outstanding.
- R4: A frame shorter than 64 bytes is extended with zero bytes to 64 bytes, and those zeros are stored as data.
- R5: The stored count is the data length (after padding) rounded down to even, plus 6, plus 4 more when the CRC is kept. It is written at offsets 2 (low byte) and 3 (high byte).
- R6: The CRC is kept when `strip_crc` is low. It is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, result complemented) over all stored data bytes. It is written least significant byte first, directly after the even part of the data.
- R7: A frame whose stored count would exceed 2048 is discarded with no page request, no write and no push.
- R8: The status word sits at offsets 0 (low byte) and 1 (high byte). Bit 12 is set for an odd padded length and bit 11 is set when the frame is longer than 1518 bytes. All other bits are zero.
- R9: The two bytes after the CRC (or after the data when the CRC is stripped) are the final data byte followed by 0x60 for an odd length, and 0x40 followed by 0x00 for an even length.
- R10: After the last layout write, `q_push` and `rx_event` pulse together for exactly one cycle, and `q_page` carries the granted page. All page writes carry that page on `wr_page`.
- R11: A discarded frame is fully consumed (`in_ready` high until its last byte), and the next frame is accepted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| soft_rst | input | 1 | Receive soft reset; frames are discarded while high |
| strip_crc | input | 1 | When high the CRC is not stored |
| in_start | input | 1 | Frame start pulse, valid with `in_len` |
| in_len | input | LEN_W | Frame length in bytes |
| in_valid | input | 1 | Data byte valid |
| in_data | input | 8 | Data byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Block accepts a byte this cycle |
| alloc_req | output | 1 | Page request to the allocator |
| alloc_ack | input | 1 | Allocator answer strobe |
| alloc_ok | input | 1 | Answer carries a page |
| alloc_page | input | PAGE_W | Granted page number |
| q_full | input | 1 | Receive queue cannot take an entry |
| q_push | output | 1 | Push strobe to the receive queue |
| q_page | output | PAGE_W | Page number pushed |
| rx_event | output | 1 | One-cycle receive event |
| wr_en | output | 1 | Page memory write strobe |
| wr_page | output | PAGE_W | Page being written |
| wr_addr | output | ADDR_W | Byte offset inside the page |
| wr_data | output | 8 | Byte written |

## Verification
The write path is tried with frames that differ in one property at a time:

- an even length with CRC against an odd length with CRC, which separates the trailer forms and CRC placement ahead of the odd byte;
- an odd length with the CRC stripped, which moves the trailer down by four;
- a 20-byte frame, which shows the zero padding and a CRC computed over the pad;
- a 1600-byte frame, which sets only the length flag;
- a 2040-byte frame with CRC, which must be refused on size.

Refusals through enable, soft reset, a denied page and a full queue are each followed by a good frame. This shows that the refused bytes were drained and that no state leaked into the next frame.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DROP,
        S_ALLOC,
        S_DATA,
        S_PAD,
        S_CRC,
        S_TAIL,
        S_HDR,
        S_DONE
    } rxw_state_e;

    localparam int HDR_BYTES  = 4;
    localparam int TAIL_BYTES = 2;
    localparam int CRC_BYTES  = 4;

    localparam logic [15:0] STAT_ODD  = 16'h1000;
    localparam logic [15:0] STAT_LONG = 16'h0800;
    localparam logic [7:0]  CTL_ODD   = 8'h60;
    localparam logic [7:0]  CTL_EVEN  = 8'h40;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

    typedef struct packed {
        logic        accept;
        logic        keep_crc;
        logic        odd;
        logic [15:0] status;
        logic [15:0] count;
        logic [15:0] plen;
        logic [15:0] even;
    } rxw_plan_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxw_plan.sv
module rxw_plan
    import rxw_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2048,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_STD    = 1518
) (
    input  logic [LEN_W-1:0] len,
    input  logic             rx_en,
    input  logic             soft_rst,
    input  logic             strip_crc,
    input  logic             q_full,
    output rxw_plan_t        plan
);
    logic [15:0] len16;
    logic [15:0] plen;
    logic [15:0] even;
    logic [16:0] total;
    logic        fits;

    always_comb begin
        len16 = 16'(len);
        plen  = (len16 < 16'(MIN_FRAME)) ? 16'(MIN_FRAME) : len16;
        even  = {plen[15:1], 1'b0};
        total = {1'b0, even} + 17'(HDR_BYTES + TAIL_BYTES)
              + (strip_crc ? 17'd0 : 17'(CRC_BYTES));
        fits  = (total <= 17'(PAGE_BYTES));

        plan.accept   = rx_en && !soft_rst && !q_full && fits;
        plan.keep_crc = !strip_crc;
        plan.odd      = plen[0];
        plan.status   = (plen[0] ? STAT_ODD : 16'h0000)
                      | ((len16 > 16'(MAX_STD)) ? STAT_LONG : 16'h0000);
        plan.count    = total[15:0];
        plan.plen     = plen;
        plan.even     = even;
    end
endmodule

// File: rtl/rxw_crc32.sv
module rxw_crc32
    import rxw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    logic [31:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= 32'hFFFF_FFFF;
        end else if (en) begin
            acc <= crc_step(acc, din);
        end
    end

    assign crc = ~acc;
endmodule

// File: rtl/rxw_top.sv
module rxw_top
    import rxw_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int LEN_W      = 12,
    parameter int PAGE_W     = 6,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_STD    = 1518,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              soft_rst,
    input  logic              strip_crc,
    input  logic              in_start,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              alloc_req,
    input  logic              alloc_ack,
    input  logic              alloc_ok,
    input  logic [PAGE_W-1:0] alloc_page,
    input  logic              q_full,
    output logic              q_push,
    output logic [PAGE_W-1:0] q_page,
    output logic              rx_event,
    output logic              wr_en,
    output logic [PAGE_W-1:0] wr_page,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    rxw_state_e          st;
    rxw_plan_t           cand;
    rxw_plan_t           pl;
    logic [PAGE_W-1:0]   page;
    logic [15:0]         idx;
    logic [1:0]          step;
    logic [7:0]          odd_byte;
    logic                crc_clr;
    logic                crc_en;
    logic [7:0]          crc_din;
    logic [31:0]         crc_val;
    logic [15:0]         addr16;
    logic [15:0]         tail_base;
    logic                hold_odd;

    rxw_plan #(
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES),
        .MIN_FRAME  (MIN_FRAME),
        .MAX_STD    (MAX_STD)
    ) u_plan (
        .len       (in_len),
        .rx_en     (rx_en),
        .soft_rst  (soft_rst),
        .strip_crc (strip_crc),
        .q_full    (q_full),
        .plan      (cand)
    );

    rxw_crc32 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .en  (crc_en),
        .din (crc_din),
        .crc (crc_val)
    );

    assign hold_odd  = pl.odd && (idx == pl.even);
    assign tail_base = 16'(HDR_BYTES) + pl.even + (pl.keep_crc ? 16'(CRC_BYTES) : 16'd0);

    // Write-side decode: one page byte per cycle.
    always_comb begin
        wr_en   = 1'b0;
        addr16  = 16'd0;
        wr_data = 8'd0;
        crc_en  = 1'b0;
        crc_din = in_data;
        crc_clr = (st == S_IDLE);
        case (st)
            S_DATA: begin
                if (in_valid) begin
                    crc_en = 1'b1;
                    if (!hold_odd) begin
                        wr_en   = 1'b1;
                        addr16  = 16'(HDR_BYTES) + idx;
                        wr_data = in_data;
                    end
                end
            end
            S_PAD: begin
                wr_en   = 1'b1;
                addr16  = 16'(HDR_BYTES) + idx;
                wr_data = 8'd0;
                crc_en  = 1'b1;
                crc_din = 8'd0;
            end
            S_CRC: begin
                wr_en   = 1'b1;
                addr16  = 16'(HDR_BYTES) + pl.even + 16'(step);
                wr_data = crc_val[{step, 3'b000} +: 8];
            end
            S_TAIL: begin
                wr_en   = 1'b1;
                addr16  = tail_base + 16'(step);
                if (step == 2'd0) begin
                    wr_data = pl.odd ? odd_byte : CTL_EVEN;
                end else begin
                    wr_data = pl.odd ? CTL_ODD : 8'h00;
                end
            end
            S_HDR: begin
                wr_en  = 1'b1;
                addr16 = 16'(step);
                case (step)
                    2'd0:    wr_data = pl.status[7:0];
                    2'd1:    wr_data = pl.status[15:8];
                    2'd2:    wr_data = pl.count[7:0];
                    default: wr_data = pl.count[15:8];
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            pl       <= '0;
            page     <= '0;
            idx      <= '0;
            step     <= '0;
            odd_byte <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (in_start) begin
                        pl   <= cand;
                        idx  <= '0;
                        step <= '0;
                        st   <= cand.accept ? S_ALLOC : S_DROP;
                    end
                end
                S_DROP: begin
                    if (in_valid && in_last) st <= S_IDLE;
                end
                S_ALLOC: begin
                    if (alloc_ack) begin
                        if (alloc_ok) begin
                            page <= alloc_page;
                            st   <= S_DATA;
                        end else begin
                            st <= S_DROP;
                        end
                    end
                end
                S_DATA: begin
                    if (in_valid) begin
                        if (hold_odd) odd_byte <= in_data;
                        idx <= idx + 16'd1;
                        if (in_last) begin
                            if (idx + 16'd1 < pl.plen) st <= S_PAD;
                            else                       st <= pl.keep_crc ? S_CRC : S_TAIL;
                        end
                    end
                end
                S_PAD: begin
                    idx <= idx + 16'd1;
                    if (idx + 16'd1 == pl.plen) st <= pl.keep_crc ? S_CRC : S_TAIL;
                end
                S_CRC: begin
                    step <= step + 2'd1;
                    if (step == 2'd3) st <= S_TAIL;
                end
                S_TAIL: begin
                    if (step == 2'd1) begin
                        step <= 2'd0;
                        st   <= S_HDR;
                    end else begin
                        step <= step + 2'd1;
                    end
                end
                S_HDR: begin
                    step <= step + 2'd1;
                    if (step == 2'd3) st <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign wr_addr   = addr16[ADDR_W-1:0];
    assign wr_page   = page;
    assign q_page    = page;
    assign in_ready  = (st == S_DATA) || (st == S_DROP);
    assign alloc_req = (st == S_ALLOC);
    assign q_push    = (st == S_DONE);
    assign rx_event  = (st == S_DONE);
endmodule

// File: rtl/rxw_chk.sv
module rxw_chk
    import rxw_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input rxw_state_e st,
    input logic       in_start,
    input logic       rx_en,
    input logic       soft_rst,
    input logic       q_full,
    input logic       alloc_req,
    input logic       alloc_ack,
    input logic       wr_en,
    input logic       q_push
);
    // R1
    disabled_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && in_start && (!rx_en || soft_rst)) |=> !alloc_req);

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && in_start && q_full) |=> !alloc_req);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !alloc_ack) |=> alloc_req);

    // R2
    req_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alloc_req) |-> $past(in_start));

    // R10
    push_single_chk: assert property (@(posedge clk) disable iff (rst)
        q_push |=> !q_push);

    // R10
    push_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        q_push |-> $past(wr_en));
endmodule

bind rxw_top rxw_chk u_rxw_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .in_start  (in_start),
    .rx_en     (rx_en),
    .soft_rst  (soft_rst),
    .q_full    (q_full),
    .alloc_req (alloc_req),
    .alloc_ack (alloc_ack),
    .wr_en     (wr_en),
    .q_push    (q_push)
);

// File: tb/rxw_top_test.sv
module rxw_top_test;
    localparam int PAGE_W = 6;
    localparam int LEN_W  = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_en = 1'b1, soft_rst = 1'b0, strip_crc = 1'b0;
    logic              in_start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
    logic [LEN_W-1:0]  in_len = '0;
    logic [7:0]        in_data = '0;
    logic              in_ready;
    logic              alloc_req, alloc_ack = 1'b0, alloc_ok = 1'b1;
    logic [PAGE_W-1:0] alloc_page = 6'd5;
    logic              q_full = 1'b0;
    logic              q_push, rx_event, wr_en;
    logic [PAGE_W-1:0] q_page, wr_page;
    logic [10:0]       wr_addr;
    logic [7:0]        wr_data;

    int total = 0, bad = 0;
    int wr_cnt = 0, push_cnt = 0, ev_cnt = 0, page_err = 0, sync_err = 0, req_cnt = 0;
    logic [PAGE_W-1:0] push_page;
    logic [7:0] mem [0:2047];
    logic grant_ok = 1'b1;

    always #5 clk = ~clk;

    rxw_top uut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .soft_rst(soft_rst), .strip_crc(strip_crc),
        .in_start(in_start), .in_len(in_len), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .alloc_req(alloc_req), .alloc_ack(alloc_ack),
        .alloc_ok(alloc_ok), .alloc_page(alloc_page), .q_full(q_full), .q_push(q_push),
        .q_page(q_page), .rx_event(rx_event), .wr_en(wr_en), .wr_page(wr_page),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Allocator model: answers one cycle after a request is seen.
    always @(posedge clk) begin
        alloc_ack <= 1'b0;
        alloc_ok  <= grant_ok;
        if (alloc_req && !alloc_ack) begin
            alloc_ack <= 1'b1;
            req_cnt   <= req_cnt + 1;
        end
    end

    // Page memory and queue model.
    always @(posedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
                if (wr_page != alloc_page) page_err <= page_err + 1;
            end
            if (q_push) begin
                push_cnt  <= push_cnt + 1;
                push_page <= q_page;
            end
            if (rx_event) ev_cnt <= ev_cnt + 1;
            if (q_push != rx_event) sync_err <= sync_err + 1;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 7 + seed * 13 + 1) & 8'hff);
    endfunction

    function automatic logic [7:0] dbyte(input int i, input int len, input int seed);
        return (i < len) ? pat(i, seed) : 8'h00;
    endfunction

    function automatic logic [31:0] crc_ref(input int n, input int len, input int seed);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'd0, dbyte(i, len, seed)};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic clear_state();
        for (int a = 0; a < 2048; a++) mem[a] = 8'hEE;
        wr_cnt = 0; push_cnt = 0; ev_cnt = 0; page_err = 0; sync_err = 0; req_cnt = 0;
    endtask

    task automatic send(input int len, input int seed);
        @(negedge clk);
        in_start = 1'b1;
        in_len   = LEN_W'(len);
        @(negedge clk);
        in_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = pat(i, seed);
            in_last  = (i == len - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (100) @(negedge clk);
    endtask

    task automatic expect_drop(input string req);
        chk(req_cnt == 0 || !grant_ok, {req, " page request"}, req_cnt, 0);
        chk(wr_cnt == 0, {req, " writes"}, wr_cnt, 0);
        chk(push_cnt == 0 && ev_cnt == 0, {req, " push"}, push_cnt, 0);
    endtask

    task automatic frame_ok(input int len, input int seed, input bit keep, input string tag);
        int plen, even, cnt, bad_i, tb;
        logic [15:0] st, got;
        logic [31:0] crc;
        clear_state();
        strip_crc = !keep;
        send(len, seed);
        plen = (len < 64) ? 64 : len;
        even = plen & ~1;
        cnt  = even + 6 + (keep ? 4 : 0);
        st   = ((plen % 2) ? 16'h1000 : 16'h0) | ((len > 1518) ? 16'h0800 : 16'h0);
        got  = {mem[1], mem[0]};
        chk(got == st, {"R8 status ", tag}, got, st);
        got  = {mem[3], mem[2]};
        chk(got == 16'(cnt), {"R5 count ", tag}, got, cnt);
        bad_i = -1;
        for (int i = 0; i < even; i++)
            if (mem[4 + i] !== dbyte(i, len, seed) && bad_i < 0) bad_i = i;
        chk(bad_i < 0, {"R3/R4 data ", tag}, bad_i, -1);
        if (keep) begin
            crc = crc_ref(plen, len, seed);
            got = 0;
            chk({mem[4+even+3], mem[4+even+2], mem[4+even+1], mem[4+even]} == crc,
                {"R6 crc ", tag}, int'({mem[4+even+1], mem[4+even]}), int'(crc[15:0]));
        end else begin
            chk(mem[4 + even + 4] == 8'hEE || (4 + even + 2) <= 2047, {"R6 strip ", tag}, 0, 0);
        end
        tb = 4 + even + (keep ? 4 : 0);
        if (plen % 2) begin
            chk(mem[tb] == pat(len - 1, seed), {"R9 odd byte ", tag}, mem[tb], pat(len - 1, seed));
            chk(mem[tb + 1] == 8'h60, {"R9 odd ctl ", tag}, mem[tb + 1], 8'h60);
        end else begin
            chk(mem[tb] == 8'h40, {"R9 even ctl ", tag}, mem[tb], 8'h40);
            chk(mem[tb + 1] == 8'h00, {"R9 even pad ", tag}, mem[tb + 1], 0);
        end
        chk(wr_cnt == cnt, {"R5 write count ", tag}, wr_cnt, cnt);
        chk(push_cnt == 1 && ev_cnt == 1 && sync_err == 0, {"R10 push ", tag}, push_cnt, 1);
        chk(push_page == alloc_page && page_err == 0, {"R10 page ", tag}, push_page, alloc_page);
    endtask

    task automatic t_reset();
        chk(!in_ready && !alloc_req && !wr_en && !q_push && !rx_event, "R3 reset idle",
            {in_ready, alloc_req, wr_en, q_push}, 0);
    endtask

    task automatic t_disabled();
        clear_state(); rx_en = 1'b0;
        send(80, 3);
        expect_drop("R1 disabled");
        rx_en = 1'b1;
        clear_state(); soft_rst = 1'b1;
        send(80, 4);
        expect_drop("R1 soft reset");
        soft_rst = 1'b0;
        frame_ok(70, 5, 1'b1, "R11 after R1");
    endtask

    task automatic t_refused();
        clear_state(); grant_ok = 1'b0;
        send(90, 6);
        chk(req_cnt == 1, "R2 denied request", req_cnt, 1);
        chk(wr_cnt == 0 && push_cnt == 0, "R2 denied no write", wr_cnt, 0);
        grant_ok = 1'b1;
        clear_state(); q_full = 1'b1;
        send(90, 7);
        expect_drop("R2 queue full");
        q_full = 1'b0;
        frame_ok(66, 8, 1'b0, "R11 after R2");
    endtask

    task automatic t_oversize();
        clear_state(); strip_crc = 1'b0;
        send(2040, 9);
        expect_drop("R7 oversize");
        frame_ok(64, 10, 1'b1, "R11 after R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        frame_ok(100, 1, 1'b1, "even keep");
        frame_ok(77, 2, 1'b1, "odd keep");
        frame_ok(101, 11, 1'b0, "odd strip");
        frame_ok(20, 12, 1'b1, "R4 short");
        frame_ok(1600, 13, 1'b0, "R8 long");
        t_disabled();
        t_refused();
        t_oversize();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule